// File: doc/BRIEF.md
# Two-Step Software Reset Sequencer

This block sits in the command front end of a serial flash and carries out the two-command software reset. It samples the chip-select, serial clock and serial data pins into the system clock domain and cuts the serial stream into frames bounded by chip-select. A frame counts as an opcode only when chip-select returns high after exactly eight sampled clock edges. An arming opcode (66h) in one frame, followed at once by a reset opcode (99h) in the next frame, fires the reset.

When the reset fires, the block pulses an abort line that stops any internal program or erase engine. It returns the volatile control state to its power-on values and enters a lockout. The lockout lasts a fixed number of system clocks, or a longer count if an erase was running when the reset was accepted. During the lockout, frames and volatile-state writes are dropped and the busy status stays high. The busy and suspend status bits are brought out so that a controller can check them before sending the sequence. Every opcode frame accepted outside lockout is passed on as a one-cycle strobe for the rest of the command decoder.

Top module: `swrst_seq`

## Requirements
- R1: Serial data is taken MSB first on each rising serial clock while chip-select is low. A frame commits only on the rising edge of chip-select, and only after exactly 8 bits. A committed frame outside lockout gives one `cmd_stb` pulse carrying its opcode on `cmd_op`.
- R2: A committed 66h frame outside lockout sets `armed`. This holds also when the block is already armed.
- R3: Any other frame end clears `armed`. This covers a committed opcode other than 66h and a frame with a bit count other than 8. A committed 99h frame while armed is accepted as a reset.
- R4: A 99h frame while not armed has no effect: no abort, and the volatile state is unchanged.
- R5: On acceptance, `abort` is high for exactly one cycle, and `lockout` rises in that same cycle.
- R6: On acceptance, `vol_q` returns to its default value 23'h000007. The field layout is bit 22 write-enable latch, bit 21 suspend, bits 20:19 volatile status, bits 18:11 read parameters, bits 10:3 continuous-read mode, bits 2:0 wrap (default 3'b111).
- R7: `lockout` stays high for exactly RST_CYC cycles. If `erase_in_prog` is high when the reset is accepted, it stays high for RST_ERASE_CYC cycles instead.
- R8: During lockout, a frame gives no `cmd_stb` and does not arm, and a `vol_load` is ignored.
- R9: When the lockout ends, `armed` is low, so a 99h frame without a fresh 66h frame does not reset.
- R10: `st_busy` is high whenever `lockout` or `eng_busy` is high. `st_sus` shows the suspend field of `vol_q`.
- R11: After reset, `armed`, `lockout`, `abort`, `cmd_stb` and `st_busy` are low, and `vol_q` holds its default value.
- R12: Outside lockout, `vol_load` loads `vol_in` into `vol_q` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_in | input | 1 | Chip-select pin, active low, asynchronous |
| sclk_in | input | 1 | Serial clock pin, asynchronous |
| mosi_in | input | 1 | Serial data in |
| vol_load | input | 1 | Write strobe for the volatile state |
| vol_in | input | 23 | Value for the volatile state |
| eng_busy | input | 1 | Internal program/erase engine busy |
| erase_in_prog | input | 1 | An erase is running (selects the long lockout) |
| cmd_stb | output | 1 | One-cycle strobe per committed opcode |
| cmd_op | output | 8 | Committed opcode |
| armed | output | 1 | Reset is armed |
| abort | output | 1 | One-cycle pulse that stops internal operations |
| lockout | output | 1 | Reset time in progress |
| st_busy | output | 1 | Busy status bit |
| st_sus | output | 1 | Suspend status bit |
| vol_q | output | 23 | Volatile control state |

## Verification
The hardest case to reach from the pins is a complete, well-formed frame whose closing chip-select edge lands inside the lockout window. The bench uses a reset time longer than one full frame. It starts an arming frame and a volatile write right after the abort, so both fall inside the window. It then shows that neither has any effect, and that a lone 99h after the window does nothing. Malformed 7-bit and 9-bit frames are placed between an arming frame and a reset frame to show that a bad frame length also disarms.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
  localparam logic [7:0] OP_ARM  = 8'h66;
  localparam logic [7:0] OP_FIRE = 8'h99;

  typedef struct packed {
    logic       wel;
    logic       sus;
    logic [1:0] vstat;
    logic [7:0] rparam;
    logic [7:0] crm;
    logic [2:0] wrap;
  } vol_t;

  localparam int VOL_W = $bits(vol_t);
  localparam vol_t VOL_DEF = '{wel: 1'b0, sus: 1'b0, vstat: 2'b00,
                               rparam: 8'h00, crm: 8'h00, wrap: 3'b111};

  function automatic logic is_arm(input logic ok, input logic [7:0] op);
    return ok && (op == OP_ARM);
  endfunction

  function automatic logic is_fire(input logic ok, input logic [7:0] op);
    return ok && (op == OP_FIRE);
  endfunction

  function automatic int unsigned lock_len(input logic erase,
                                           input int unsigned short_c,
                                           input int unsigned long_c);
    return erase ? long_c : short_c;
  endfunction
endpackage

// File: rtl/swrst_frame_rx.sv
module swrst_frame_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int OP_W        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n_in,
  input  logic            sclk_in,
  input  logic            mosi_in,
  output logic            frame_done,
  output logic            frame_ok,
  output logic [OP_W-1:0] frame_op
);
  localparam int CW = $clog2(OP_W + 2);
  localparam logic [CW-1:0] CNT_SAT = CW'(OP_W + 1);

  // stage layout per entry: {mosi, sclk, cs_n}
  logic [SYNC_STAGES-1:0][2:0] stg;
  logic [2:0] prv;
  logic [OP_W-1:0] sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= {SYNC_STAGES{3'b001}};
      prv <= 3'b001;
    end else begin
      stg <= {stg[SYNC_STAGES-2:0], {mosi_in, sclk_in, cs_n_in}};
      prv <= stg[SYNC_STAGES-1];
    end
  end

  logic s_cs, s_sclk, s_mosi;
  assign s_cs   = stg[SYNC_STAGES-1][0];
  assign s_sclk = stg[SYNC_STAGES-1][1];
  assign s_mosi = stg[SYNC_STAGES-1][2];

  logic ev_sclk_rise, ev_cs_fall, ev_cs_rise;
  assign ev_sclk_rise = s_sclk && !prv[1] && !s_cs;
  assign ev_cs_fall   = !s_cs && prv[0];
  assign ev_cs_rise   = s_cs && !prv[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '0;
      cnt        <= '0;
      frame_done <= 1'b0;
      frame_ok   <= 1'b0;
      frame_op   <= '0;
    end else begin
      if (ev_cs_fall) begin
        cnt <= '0;
      end else if (ev_sclk_rise) begin
        sh <= {sh[OP_W-2:0], s_mosi};
        if (cnt != CNT_SAT) cnt <= cnt + CW'(1);
      end
      frame_done <= ev_cs_rise;
      if (ev_cs_rise) begin
        frame_op <= sh;
        frame_ok <= (cnt == CW'(OP_W));
      end
    end
  end
endmodule

// File: rtl/swrst_arm_ctl.sv
module swrst_arm_ctl import swrst_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_done,
  input  logic       frame_ok,
  input  logic [7:0] frame_op,
  input  logic       locked,
  output logic       armed,
  output logic       take,
  output logic       accept
);
  assign take   = frame_done && frame_ok && !locked;
  assign accept = take && armed && is_fire(frame_ok, frame_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (locked)     armed <= 1'b0;
    else if (frame_done) armed <= is_arm(frame_ok, frame_op);
  end
endmodule

// File: rtl/swrst_lock_timer.sv
module swrst_lock_timer import swrst_pkg::*; #(
  parameter int unsigned SHORT_C = 1000,
  parameter int unsigned LONG_C  = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic erase,
  output logic lockout
);
  localparam int unsigned MAXC = (LONG_C > SHORT_C) ? LONG_C : SHORT_C;
  localparam int TW = $clog2(MAXC + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= TW'(lock_len(erase, SHORT_C, LONG_C));
    else if (cnt != '0)  cnt <= cnt - TW'(1);
  end

  assign lockout = (cnt != '0);
endmodule

// File: rtl/swrst_seq.sv
module swrst_seq import swrst_pkg::*; #(
  parameter int unsigned RST_CYC       = 1000,
  parameter int unsigned RST_ERASE_CYC = 4000,
  parameter int          SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_in,
  input  logic             sclk_in,
  input  logic             mosi_in,
  input  logic             vol_load,
  input  logic [VOL_W-1:0] vol_in,
  input  logic             eng_busy,
  input  logic             erase_in_prog,
  output logic             cmd_stb,
  output logic [7:0]       cmd_op,
  output logic             armed,
  output logic             abort,
  output logic             lockout,
  output logic             st_busy,
  output logic             st_sus,
  output logic [VOL_W-1:0] vol_q
);
  // named internal events, also used by the bound checker
  logic       f_done, f_ok;
  logic [7:0] f_op;
  logic       take, accept;
  vol_t       vol_r;

  swrst_frame_rx #(.SYNC_STAGES(SYNC_STAGES), .OP_W(8)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sclk_in(sclk_in),
    .mosi_in(mosi_in), .frame_done(f_done), .frame_ok(f_ok), .frame_op(f_op)
  );

  swrst_arm_ctl u_arm (
    .clk(clk), .rst_n(rst_n), .frame_done(f_done), .frame_ok(f_ok),
    .frame_op(f_op), .locked(lockout), .armed(armed), .take(take),
    .accept(accept)
  );

  swrst_lock_timer #(.SHORT_C(RST_CYC), .LONG_C(RST_ERASE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept), .erase(erase_in_prog),
    .lockout(lockout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_stb <= 1'b0;
      cmd_op  <= '0;
      abort   <= 1'b0;
      vol_r   <= VOL_DEF;
    end else begin
      cmd_stb <= take;
      if (take) cmd_op <= f_op;
      abort <= accept;
      if (accept)                    vol_r <= VOL_DEF;
      else if (vol_load && !lockout) vol_r <= vol_t'(vol_in);
    end
  end

  assign vol_q   = vol_r;
  assign st_sus  = vol_r.sus;
  assign st_busy = lockout || eng_busy;
endmodule

// File: rtl/swrst_seq_chk.sv
module swrst_seq_chk import swrst_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             abort,
  input logic             lockout,
  input logic             armed,
  input logic             cmd_stb,
  input logic [VOL_W-1:0] vol_q,
  input logic             frame_done,
  input logic             frame_ok,
  input logic [7:0]       frame_op
);
  a_r2_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_ok && frame_op == OP_ARM && !lockout) |=> armed);

  a_r4_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $past(armed));

  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);

  a_r5_lock_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> lockout);

  a_r5_lock_starts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockout) |-> abort);

  a_r6_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (vol_q == VOL_DEF));

  a_r8_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout && !abort) |-> !cmd_stb);

  a_r8_vol_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout && !abort) |-> $stable(vol_q));

  a_r9_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |-> !armed);
endmodule

bind swrst_seq swrst_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .lockout(lockout),
  .armed(armed), .cmd_stb(cmd_stb), .vol_q(vol_q),
  .frame_done(f_done), .frame_ok(f_ok), .frame_op(f_op)
);

// File: tb/swrst_seq_test.sv
module swrst_seq_test;
  localparam int CLK_P = 10;
  localparam int SHORT_C = 120;
  localparam int LONG_C = 250;
  localparam int PH = 3;
  localparam logic [22:0] DEF = 23'h000007;
  localparam logic [22:0] V1  = 23'h6B3C1A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n_in = 1'b1, sclk_in = 1'b0, mosi_in = 1'b0;
  logic vol_load = 1'b0, eng_busy = 1'b0, erase_in_prog = 1'b0;
  logic [22:0] vol_in = '0;
  logic cmd_stb, armed, abort, lockout, st_busy, st_sus;
  logic [7:0] cmd_op;
  logic [22:0] vol_q;

  int checks = 0, errors = 0, abort_cnt = 0, run = 0;
  bit done = 0;
  int exp_ops[$];
  int exp_len[$];

  always #(CLK_P/2) clk = ~clk;

  swrst_seq #(.RST_CYC(SHORT_C), .RST_ERASE_CYC(LONG_C)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sclk_in(sclk_in),
    .mosi_in(mosi_in), .vol_load(vol_load), .vol_in(vol_in),
    .eng_busy(eng_busy), .erase_in_prog(erase_in_prog), .cmd_stb(cmd_stb),
    .cmd_op(cmd_op), .armed(armed), .abort(abort), .lockout(lockout),
    .st_busy(st_busy), .st_sus(st_sus), .vol_q(vol_q)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard for opcodes and lockout lengths, abort counting
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (abort) abort_cnt++;
      if (cmd_stb) begin
        if (exp_ops.size() == 0) chk(0, "R1/R8", "unexpected cmd_stb", cmd_op, 0);
        else begin
          int e;
          e = exp_ops.pop_front();
          chk(cmd_op == e[7:0], "R1", "cmd_op", cmd_op, e);
        end
      end
      if (lockout) run++;
      else if (run > 0) begin
        if (exp_len.size() == 0) chk(0, "R7", "unexpected lockout", run, 0);
        else begin
          int e;
          e = exp_len.pop_front();
          chk(run == e, "R7", "lockout length", run, e);
        end
        run = 0;
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] bits, input int n, input bit expect_cmd);
    @(negedge clk);
    cs_n_in = 1'b0;
    wclk(PH);
    for (int i = 0; i < n; i++) begin
      mosi_in = bits[n-1-i];
      wclk(PH);
      sclk_in = 1'b1;
      wclk(PH);
      sclk_in = 1'b0;
    end
    wclk(PH);
    if (expect_cmd && n == 8) exp_ops.push_back(int'(bits[7:0]));
    cs_n_in = 1'b1;
    wclk(8);
  endtask

  task automatic load_vol(input logic [22:0] v);
    @(negedge clk);
    vol_in = v; vol_load = 1'b1;
    @(negedge clk);
    vol_load = 1'b0;
    wclk(1);
  endtask

  task automatic wait_unlock();
    while (lockout) @(negedge clk);
    wclk(5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(3);
    // R11 reset state
    chk(vol_q == DEF, "R11", "vol_q", vol_q, DEF);
    chk(!armed && !lockout && !abort && !cmd_stb && !st_busy, "R11", "flags",
        {armed, lockout, abort, cmd_stb, st_busy}, 0);

    // R12 load, R10 status
    load_vol(V1);
    chk(vol_q == V1, "R12", "vol_q after load", vol_q, V1);
    chk(st_sus == 1'b1, "R10", "st_sus", st_sus, 1);
    eng_busy = 1'b1; wclk(1);
    chk(st_busy == 1'b1, "R10", "st_busy eng", st_busy, 1);
    eng_busy = 1'b0; wclk(1);
    chk(st_busy == 1'b0, "R10", "st_busy idle", st_busy, 0);

    // R1 plain opcode, R4 lone 99h
    send_frame(16'h00A5, 8, 1);
    send_frame(16'h0099, 8, 1);
    chk(abort_cnt == 0, "R4", "abort count", abort_cnt, 0);
    chk(vol_q == V1, "R4", "vol_q kept", vol_q, V1);

    // R2 arm, R5/R6 accepted reset
    send_frame(16'h0066, 8, 1);
    chk(armed == 1'b1, "R2", "armed", armed, 1);
    exp_len.push_back(SHORT_C);
    send_frame(16'h0099, 8, 1);
    chk(abort_cnt == 1, "R5", "abort count", abort_cnt, 1);
    chk(lockout == 1'b1 && st_busy == 1'b1, "R5", "lockout", lockout, 1);
    chk(vol_q == DEF, "R6", "vol_q default", vol_q, DEF);
    chk(st_sus == 1'b0 && armed == 1'b0, "R6", "sus/armed", {st_sus, armed}, 0);

    // R8 frame and write during lockout
    send_frame(16'h0066, 8, 0);
    load_vol(V1);
    chk(lockout == 1'b1, "R8", "still locked", lockout, 1);
    chk(armed == 1'b0, "R8", "not armed", armed, 0);
    chk(vol_q == DEF, "R8", "vol write ignored", vol_q, DEF);
    wait_unlock();
    // R9 lone 99h after lockout
    send_frame(16'h0099, 8, 1);
    chk(abort_cnt == 1, "R9", "no reset after lockout", abort_cnt, 1);

    // R3 other opcode disarms
    load_vol(V1);
    send_frame(16'h0066, 8, 1);
    send_frame(16'h0005, 8, 1);
    chk(armed == 1'b0, "R3", "disarm by opcode", armed, 0);
    send_frame(16'h0099, 8, 1);
    chk(abort_cnt == 1, "R3", "no reset after opcode", abort_cnt, 1);

    // R3 9-bit frame disarms, no cmd
    send_frame(16'h0066, 8, 1);
    send_frame(16'h0133, 9, 0);
    chk(armed == 1'b0, "R3", "disarm by 9 bits", armed, 0);
    send_frame(16'h0099, 8, 1);
    chk(abort_cnt == 1, "R3", "no reset after 9 bits", abort_cnt, 1);

    // R3 7-bit frame disarms
    send_frame(16'h0066, 8, 1);
    send_frame(16'h0066, 7, 0);
    chk(armed == 1'b0, "R3", "disarm by 7 bits", armed, 0);
    chk(vol_q == V1, "R4", "vol_q kept", vol_q, V1);

    // R2 re-arm, R7 long lockout with erase
    send_frame(16'h0066, 8, 1);
    send_frame(16'h0066, 8, 1);
    chk(armed == 1'b1, "R2", "re-armed", armed, 1);
    erase_in_prog = 1'b1;
    exp_len.push_back(LONG_C);
    send_frame(16'h0099, 8, 1);
    erase_in_prog = 1'b0;
    chk(abort_cnt == 2, "R7", "abort count", abort_cnt, 2);
    chk(vol_q == DEF, "R6", "vol_q default", vol_q, DEF);
    wait_unlock();

    chk(exp_ops.size() == 0, "R1", "pending opcodes", exp_ops.size(), 0);
    chk(exp_len.size() == 0, "R7", "pending lockouts", exp_len.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule